// File: doc/BRIEF.md
# Receive Bit Buffer with Fill-Level Interrupt

This block sits behind a receiver's clock recovery. Each recovered bit comes with a one-cycle strobe. While the buffer is enabled, the bit is appended to a 16-entry bit store. A host drains the store serially: it pulls its buffer-select line low and toggles its serial clock. The oldest stored bit is always presented on the data-out pin, and each falling serial-clock edge discards it so that the next bit appears.

A programmable fill level drives an interrupt, given on two pins of opposite polarity. A level of 1 makes the interrupt a plain "buffer not empty" flag. A level of 0 stands for 16, which means "buffer full". When the store is full, further bits are dropped and a sticky overflow flag is set. The host clears the flag with a status-read pulse.

When buffering is disabled, the store is flushed and kept empty. The raw bit and its strobe are then routed straight to a pair of direct pins. The host serial clock and select are treated as asynchronous and are synchronised inside the block.

A control state machine has three states:
- **OFF**: buffering disabled, store flushed.
- **RUN**: collecting bits.
- **SHIFT**: host selected, read-out active.

Its transitions are:
- OFF→RUN when enabled.
- RUN→SHIFT when the synchronised select goes low.
- SHIFT→RUN when the select goes high.
- RUN→OFF and SHIFT→OFF when the enable clears.

Top module: `rxbuf_top`

## Requirements
- R1: After reset the store is empty: `lvl_irq`=0, `lvl_irq_n`=1, `ovf_flag`=0 and `host_dout`=0.
- R2: With `cfg_buf_en`=0, `raw_data` follows `rx_bit` and `raw_clk` follows `rx_strobe`. With `cfg_buf_en`=1, both are held at 0.
- R3: A bit is stored only on a cycle with `rx_strobe`=1 while enabled. Bits presented without a strobe, or while disabled, leave the store unchanged.
- R4: While selected, `host_dout` shows the oldest stored bit. Each falling edge of `host_sclk` with `host_sel_n`=0 removes that bit, so bits leave oldest first. `host_dout` is 0 when not selected or when the store is empty.
- R5: `lvl_irq` is 1 exactly when the stored count is at least the threshold. The threshold is `cfg_level` for values 1..15, and a value of 0 means 16. The interrupt drops as soon as a read takes the count below the threshold.
- R6: `lvl_irq_n` is always the complement of `lvl_irq`.
- R7: With `cfg_level`=1, `lvl_irq` acts as a not-empty flag.
- R8: A strobed bit arriving while 16 bits are stored is dropped and sets `ovf_flag`. The flag stays set until a `status_rd` pulse clears it.
- R9: Clearing `cfg_buf_en` flushes the store, so the stored count is zero on re-enable.
- R10: The store holds exactly 16 bits, and all 16 read back intact.
- R11: Serial-clock edges while not selected (state RUN) remove no bits. Read-out happens only in state SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_buf_en | input | 1 | Buffering enable |
| cfg_level | input | 4 | Interrupt fill threshold (0 means 16) |
| rx_bit | input | 1 | Recovered data bit |
| rx_strobe | input | 1 | One-cycle recovered bit strobe |
| host_sclk | input | 1 | Host serial clock (asynchronous) |
| host_sel_n | input | 1 | Host buffer select, active low (asynchronous) |
| status_rd | input | 1 | Status-read pulse, clears overflow |
| host_dout | output | 1 | Serial buffer data to host |
| lvl_irq | output | 1 | Fill-level interrupt, active high |
| lvl_irq_n | output | 1 | Fill-level interrupt, active low |
| ovf_flag | output | 1 | Sticky overflow flag |
| raw_data | output | 1 | Direct bit output when buffering disabled |
| raw_clk | output | 1 | Direct bit strobe when buffering disabled |

## Verification
The assertions are checked on every cycle. They cover the following:
- The count is bounded at 16.
- The count never grows without a strobe.
- A cleared enable empties the store by the next cycle.
- The overflow flag holds until a status read.
- An empty store never interrupts.
- Data-out stays quiet outside the SHIFT state.

Bit ordering, the exact threshold per level, the dropping of the seventeenth bit and the direct-pin routing can only be shown by the bench's sweeps. The bench covers every level with full fill and drain passes and patterned data.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SHIFT = 2'd2
    } rxbuf_state_e;
endpackage

// File: rtl/rxbuf_sync.sv
// Synchronises the host serial clock and select, detects serial-clock falls.
module rxbuf_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sel_n_in,
    output logic sclk_fall,
    output logic sel_active
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sclk_pipe;
    logic [LAST:0] sel_pipe;
    logic          sclk_last;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_pipe <= '0;
                    sel_pipe  <= '1;
                end else begin
                    sclk_pipe <= sclk_in;
                    sel_pipe  <= sel_n_in;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_pipe <= '0;
                    sel_pipe  <= '1;
                end else begin
                    sclk_pipe <= {sclk_pipe[LAST-1:0], sclk_in};
                    sel_pipe  <= {sel_pipe[LAST-1:0], sel_n_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_last <= 1'b0;
        else        sclk_last <= sclk_pipe[LAST];
    end

    assign sclk_fall  = sclk_last & ~sclk_pipe[LAST];
    assign sel_active = ~sel_pipe[LAST];
endmodule

// File: rtl/rxbuf_ctrl.sv
// Control state machine: OFF / RUN / SHIFT.
module rxbuf_ctrl
    import rxbuf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         sel_active,
    output rxbuf_state_e state_q,
    output logic         accept,
    output logic         flush,
    output logic         readout
);
    rxbuf_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en) state_d = ST_RUN;
            ST_RUN:   if (!en) state_d = ST_OFF;
                      else if (sel_active) state_d = ST_SHIFT;
            ST_SHIFT: if (!en) state_d = ST_OFF;
                      else if (!sel_active) state_d = ST_RUN;
            default:  state_d = ST_OFF;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        flush   = 1'b0;
        readout = 1'b0;
        unique case (state_q)
            ST_OFF:   flush = 1'b1;
            ST_RUN:   begin accept = en; flush = !en; end
            ST_SHIFT: begin accept = en; flush = !en; readout = en; end
            default:  flush = 1'b1;
        endcase
    end
endmodule

// File: rtl/rxbuf_store.sv
// Bit store: index 0 is the oldest bit; reads shift toward index 0.
module rxbuf_store #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             bit_in,
    input  logic             pop,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             head,
    output logic             ovf_q
);
    localparam int IDX_W = CNT_W - 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [DEPTH-1:0] bits_q, bits_d;
    logic [CNT_W-1:0] base, cnt_d;
    logic             pop_ok, push_ok;

    assign pop_ok  = pop && (cnt_q != '0);
    assign base    = cnt_q - CNT_W'(pop_ok);
    assign push_ok = push && (base < DEPTH_C);

    always_comb begin
        bits_d = pop_ok ? (bits_q >> 1) : bits_q;
        if (push_ok) bits_d[base[IDX_W-1:0]] = bit_in;
        cnt_d = base + CNT_W'(push_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else begin
            bits_q <= bits_d;
            cnt_q  <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ovf_q <= 1'b0;
        else if (push && !push_ok) ovf_q <= 1'b1;
        else if (ovf_clr)          ovf_q <= 1'b0;
    end

    assign head = bits_q[0] & (cnt_q != '0);
endmodule

// File: rtl/rxbuf_irq.sv
// Fill-level compare; a level field of zero selects the full depth.
module rxbuf_irq #(
    parameter int LVL_W = 4,
    parameter int CNT_W = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             irq_n
);
    localparam int DEPTH = 1 << LVL_W;
    logic [CNT_W-1:0] thr;

    assign thr   = (level == '0) ? CNT_W'(DEPTH) : CNT_W'(level);
    assign irq   = (cnt >= thr);
    assign irq_n = ~irq;
endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top
    import rxbuf_pkg::*;
#(
    parameter int LVL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_buf_en,
    input  logic [LVL_W-1:0] cfg_level,
    input  logic             rx_bit,
    input  logic             rx_strobe,
    input  logic             host_sclk,
    input  logic             host_sel_n,
    input  logic             status_rd,
    output logic             host_dout,
    output logic             lvl_irq,
    output logic             lvl_irq_n,
    output logic             ovf_flag,
    output logic             raw_data,
    output logic             raw_clk
);
    localparam int DEPTH = 1 << LVL_W;
    localparam int CNT_W = LVL_W + 1;

    rxbuf_state_e     state_q;
    logic             accept, flush, readout;
    logic             sclk_fall, sel_active;
    logic [CNT_W-1:0] fill_cnt;
    logic             head;

    rxbuf_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .sclk_in(host_sclk), .sel_n_in(host_sel_n),
        .sclk_fall(sclk_fall), .sel_active(sel_active)
    );

    rxbuf_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_buf_en), .sel_active(sel_active),
        .state_q(state_q), .accept(accept), .flush(flush), .readout(readout)
    );

    rxbuf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(accept & rx_strobe), .bit_in(rx_bit),
        .pop(readout & sclk_fall), .ovf_clr(status_rd),
        .cnt_q(fill_cnt), .head(head), .ovf_q(ovf_flag)
    );

    rxbuf_irq #(.LVL_W(LVL_W), .CNT_W(CNT_W)) irq_i (
        .level(cfg_level), .cnt(fill_cnt), .irq(lvl_irq), .irq_n(lvl_irq_n)
    );

    assign host_dout = readout & head;
    assign raw_data  = ~cfg_buf_en & rx_bit;
    assign raw_clk   = ~cfg_buf_en & rx_strobe;
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_buf_en,
    input logic             rx_strobe,
    input logic             status_rd,
    input logic             host_dout,
    input logic             lvl_irq,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] cnt,
    input rxbuf_state_e     state
);
    p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_no_strobe_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |=> cnt <= $past(cnt));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_buf_en |=> cnt == '0);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !status_rd |=> ovf_flag);

    p_empty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == '0 |-> !lvl_irq);

    p_dout_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_SHIFT |-> !host_dout);

    p_off_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_OFF |-> cnt == '0);
endmodule

bind rxbuf_top rxbuf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_buf_en(cfg_buf_en), .rx_strobe(rx_strobe),
    .status_rd(status_rd), .host_dout(host_dout), .lvl_irq(lvl_irq),
    .ovf_flag(ovf_flag), .cnt(fill_cnt), .state(state_q)
);

// File: tb/rxbuf_top_tb_top.sv
module rxbuf_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_buf_en = 1'b0;
    logic [3:0] cfg_level = 4'd0;
    logic rx_bit = 1'b0, rx_strobe = 1'b0;
    logic host_sclk = 1'b0, host_sel_n = 1'b1, status_rd = 1'b0;
    logic host_dout, lvl_irq, lvl_irq_n, ovf_flag, raw_data, raw_clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxbuf_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_buf_en(cfg_buf_en), .cfg_level(cfg_level),
        .rx_bit(rx_bit), .rx_strobe(rx_strobe), .host_sclk(host_sclk),
        .host_sel_n(host_sel_n), .status_rd(status_rd), .host_dout(host_dout),
        .lvl_irq(lvl_irq), .lvl_irq_n(lvl_irq_n), .ovf_flag(ovf_flag),
        .raw_data(raw_data), .raw_clk(raw_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_bit(input logic b);
        @(negedge clk);
        rx_bit = b; rx_strobe = 1'b1;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic read_bit(output logic v);
        host_sclk = 1'b1;
        wait_n(4);
        v = host_dout;
        host_sclk = 1'b0;
        wait_n(4);
    endtask

    function automatic logic pat(input int k, input int s);
        return logic'(((k * 7 + s * 3) % 5) < 2);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic v;
        int thr;
        wait_n(3);
        // R1 reset state
        chk(lvl_irq == 0, "R1 irq", lvl_irq, 0);
        chk(lvl_irq_n == 1, "R1 irq_n", lvl_irq_n, 1);
        chk(ovf_flag == 0, "R1 ovf", ovf_flag, 0);
        chk(host_dout == 0, "R1 dout", host_dout, 0);
        rst_n = 1'b1;
        wait_n(2);

        // R2 direct pins while disabled; R3 nothing stored while disabled
        @(negedge clk); rx_bit = 1'b1; rx_strobe = 1'b1;
        #1;
        chk(raw_data == 1, "R2 raw_data", raw_data, 1);
        chk(raw_clk == 1, "R2 raw_clk", raw_clk, 1);
        @(negedge clk); rx_strobe = 1'b0; rx_bit = 1'b0;
        #1;
        chk(raw_clk == 0, "R2 raw_clk low", raw_clk, 0);
        cfg_level = 4'd1; cfg_buf_en = 1'b1;
        wait_n(3);
        chk(lvl_irq == 0, "R3 disabled bits not stored", lvl_irq, 0);
        // R3 bits without strobe ignored
        for (int i = 0; i < 6; i++) begin @(negedge clk); rx_bit = ~rx_bit; end
        wait_n(2);
        chk(lvl_irq == 0, "R3 unstrobed ignored", lvl_irq, 0);
        // R2 direct pins quiet when enabled
        @(negedge clk); rx_bit = 1'b1; rx_strobe = 1'b1;
        #1;
        chk(raw_clk == 0 && raw_data == 0, "R2 quiet enabled", raw_clk, 0);
        @(negedge clk); rx_strobe = 1'b0;
        wait_n(2);
        chk(lvl_irq == 1, "R7 not empty", lvl_irq, 1);
        // R4 not selected: dout stays 0
        chk(host_dout == 0, "R4 dout unselected", host_dout, 0);
        // R11 sclk without select removes nothing
        for (int i = 0; i < 3; i++) begin
            host_sclk = 1'b1; wait_n(4); host_sclk = 1'b0; wait_n(4);
        end
        chk(lvl_irq == 1, "R11 no pop unselected", lvl_irq, 1);
        // R9 flush on disable
        push_bit(1'b0); push_bit(1'b1);
        cfg_buf_en = 1'b0; wait_n(2);
        cfg_buf_en = 1'b1; wait_n(3);
        chk(lvl_irq == 0, "R9 flushed", lvl_irq, 0);
        cfg_buf_en = 1'b0; wait_n(3);

        // Sweep all levels: fill to 16, drain oldest first
        for (int lvl = 0; lvl < 16; lvl++) begin
            thr = (lvl == 0) ? DEPTH : lvl;
            cfg_level = 4'(lvl); cfg_buf_en = 1'b1;
            wait_n(3);
            for (int n = 1; n <= DEPTH; n++) begin
                push_bit(pat(n - 1, lvl));
                wait_n(2);
                chk(lvl_irq == (n >= thr), (lvl == 1) ? "R7 level one" : "R5 fill", lvl_irq, int'(n >= thr));
                chk(lvl_irq_n == ~lvl_irq, "R6 polarity", lvl_irq_n, int'(~lvl_irq));
            end
            chk(ovf_flag == 0, "R10 full no overflow", ovf_flag, 0);
            host_sel_n = 1'b0; wait_n(4);
            for (int k = 0; k < DEPTH; k++) begin
                read_bit(v);
                chk(v == pat(k, lvl), "R4 R10 order", v, int'(pat(k, lvl)));
                chk(lvl_irq == ((DEPTH - 1 - k) >= thr), "R5 drain", lvl_irq, int'((DEPTH - 1 - k) >= thr));
            end
            read_bit(v);
            chk(v == 0, "R4 empty dout", v, 0);
            host_sel_n = 1'b1; wait_n(4);
            cfg_buf_en = 1'b0; wait_n(3);
        end

        // R8 overflow: 17th bit dropped, flag sticky until status read
        cfg_level = 4'd0; cfg_buf_en = 1'b1; wait_n(3);
        for (int n = 0; n < DEPTH; n++) push_bit(pat(n, 9));
        push_bit(~pat(DEPTH - 1, 9));
        wait_n(2);
        chk(ovf_flag == 1, "R8 overflow set", ovf_flag, 1);
        wait_n(10);
        chk(ovf_flag == 1, "R8 overflow sticky", ovf_flag, 1);
        host_sel_n = 1'b0; wait_n(4);
        for (int k = 0; k < DEPTH; k++) begin
            read_bit(v);
            chk(v == pat(k, 9), "R8 kept first sixteen", v, int'(pat(k, 9)));
        end
        read_bit(v);
        chk(v == 0, "R8 dropped bit absent", v, 0);
        host_sel_n = 1'b1; wait_n(4);
        chk(ovf_flag == 1, "R8 sticky after read", ovf_flag, 1);
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
        wait_n(1);
        chk(ovf_flag == 0, "R8 cleared by status", ovf_flag, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule